// File: doc/BRIEF.md
# Interlaced Video Raster Receiver

This block sits directly behind the 8-bit parallel output of a video decoder. It runs on the decoder's pixel clock and samples the data byte and the two active-low sync inputs on every rising edge. It reconstructs the raster position from the sync inputs alone. A horizontal cycle counter is cleared by each falling edge of the horizontal sync. A line counter steps on that same edge. A falling edge of the vertical sync clears the line counter and flips a field flag.

The byte stream repeats luma, blue chroma, luma, red chroma. One chroma pair is shared by two neighbouring pixels. After horizontal blanking ends, the block groups every four bytes into one 32-bit two-pixel word. It raises a one-cycle valid strobe when that word belongs to an active line of the current field.

The defaults describe a 1716-cycle line whose first 276 cycles are blanking. The frame has 525 lines. One field is preceded by 20 blanking lines and the other by 21, and each field carries 242 active lines. All of these are parameters. Downstream logic uses the word, the strobe and the raster position to scale, convert or store the picture.

Top module: `vid_raster_rx`

## Requirements
- R1: A synchronous active-low reset clears the horizontal counter, line counter, field flag, valid strobe and output word to zero.
- R2: If the horizontal sync is first sampled low at edge k, the horizontal counter reads 0 after edge k+1 and then rises by one per edge. A sync held low for several cycles clears the counter only once.
- R3: Without a further sync fall, the horizontal counter stops at its all-ones value (2047 for the default 11-bit width), and no word is emitted while it is stopped there.
- R4: The line counter rises by one on each horizontal sync fall with the same latency as R2, and stops at its all-ones value (1023 for the default 10-bit width).
- R5: A vertical sync fall, with the latency of R2, clears the line counter and inverts the field flag. It overrides a horizontal sync fall seen in the same cycle. A vertical sync held low for several lines acts once.
- R6: A line is active when the line counter lies in [VB_EVEN, VB_EVEN+ACT_LINES) with field flag 0, or in [VB_ODD, VB_ODD+ACT_LINES) with field flag 1. The valid strobe is never raised for a word of an inactive line.
- R7: Byte index n is n cycles after the byte sampled with the first low horizontal sync. Bytes HBLANK+4m to HBLANK+4m+3 of an active line form one word, packed first byte to last as bits 31:24, 23:16, 15:8 and 7:0. The word and its strobe appear two edges after its last byte is sampled.
- R8: The valid strobe is high for exactly one cycle per word, and the output word holds its value while the strobe is low.
- R9: A word left incomplete by a horizontal sync is dropped. The first word of the next line is made of bytes HBLANK to HBLANK+3 of that line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock of the decoder |
| rst_n | input | 1 | Synchronous active-low reset |
| vd_data | input | 8 | Decoder data byte |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| pair_word | output | 32 | Two-pixel word: Y0, U, Y1, V from high to low byte |
| pair_valid | output | 1 | One-cycle strobe for a new active-picture word |
| h_pos | output | $clog2(LINE_CYCLES) | Horizontal cycle counter |
| line_pos | output | $clog2(FRAME_LINES) | Line counter since the last vertical sync fall |
| field_odd | output | 1 | Field flag, inverted on each vertical sync fall |

## Verification
The bench drives a horizontal sync held low for three cycles instead of two. A receiver that reacted to the level rather than the edge would clear its horizontal count repeatedly and shift every word by a byte. The vertical sync is made to fall on the same cycle as a horizontal sync fall, and a design that let the line step win would start the field at line 1 and misplace the active window by a line. A line ends two bytes into a word. A packer that kept its byte phase across lines would emit a mixed word or misalign the next line, and the bench compares the first word of the following line. Long runs without sync check that both counters stop at all-ones, where a wrapping counter would reopen the active window and emit spurious words.

// File: rtl/vrr_pkg.sv
// Shared types for the interlaced raster receiver.
// Assumes a byte-wide decoder bus carrying luma/chroma in Y,U,Y,V order.
package vrr_pkg;

    typedef logic [7:0] vbyte_t;

    // Two-pixel word, first byte received in the top byte.
    typedef struct packed {
        vbyte_t y0;
        vbyte_t cb;
        vbyte_t y1;
        vbyte_t cr;
    } pair_word_t;

    localparam int LANES = 4;

endpackage

// File: rtl/vrr_sync_edge.sv
// Falling-edge detector for a group of active-low sync inputs.
// Samples each input once, keeps one older copy, and flags a high-to-low
// change for exactly one cycle. Both registers reset to the idle (high) level.
module vrr_sync_edge #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] sync_n,
    output logic [N-1:0] fall
);

    logic [N-1:0] cur_q;
    logic [N-1:0] old_q;

    // Two-stage sample of the sync lines.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q <= '1;
            old_q <= '1;
        end else begin
            cur_q <= sync_n;
            old_q <= cur_q;
        end
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_edge
            assign fall[i] = old_q[i] & ~cur_q[i];

            // A detected fall can never repeat on the next cycle (R2, R5).
            assert_single_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
                fall[i] |=> !fall[i]);
        end
    endgenerate

endmodule

// File: rtl/vrr_raster_count.sv
// Raster position tracker.
// Horizontal counter cleared by a horizontal sync fall, otherwise stepping
// and holding at all-ones. Line counter steps on the horizontal fall and is
// cleared by a vertical fall, which also inverts the field flag.
// Also decodes whether the current line sits in the active picture.
module vrr_raster_count #(
    parameter int HW        = 11,
    parameter int VW        = 10,
    parameter int VB_EVEN   = 20,
    parameter int VB_ODD    = 21,
    parameter int ACT_LINES = 242
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hs_fall,
    input  logic          vs_fall,
    output logic [HW-1:0] h_cnt,
    output logic [VW-1:0] v_cnt,
    output logic          field,
    output logic          line_act
);

    localparam logic [HW-1:0] H_MAX    = {HW{1'b1}};
    localparam logic [VW-1:0] V_MAX    = {VW{1'b1}};
    localparam logic [VW-1:0] EVEN_LO  = VW'(VB_EVEN);
    localparam logic [VW-1:0] EVEN_HI  = VW'(VB_EVEN + ACT_LINES);
    localparam logic [VW-1:0] ODD_LO   = VW'(VB_ODD);
    localparam logic [VW-1:0] ODD_HI   = VW'(VB_ODD + ACT_LINES);

    logic [VW-1:0] win_lo;
    logic [VW-1:0] win_hi;

    // Horizontal cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n)              h_cnt <= '0;
        else if (hs_fall)        h_cnt <= '0;
        else if (h_cnt != H_MAX) h_cnt <= h_cnt + HW'(1);
    end

    // Line counter and field flag; vertical fall has priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v_cnt <= '0;
            field <= 1'b0;
        end else if (vs_fall) begin
            v_cnt <= '0;
            field <= ~field;
        end else if (hs_fall && v_cnt != V_MAX) begin
            v_cnt <= v_cnt + VW'(1);
        end
    end

    // Active-line window chosen by the field flag.
    always_comb begin
        win_lo   = field ? ODD_LO : EVEN_LO;
        win_hi   = field ? ODD_HI : EVEN_HI;
        line_act = (v_cnt >= win_lo) && (v_cnt < win_hi);
    end

    assert_hclear_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hs_fall |=> h_cnt == '0);

    assert_hstep_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_fall && h_cnt != H_MAX) |=> h_cnt == $past(h_cnt) + HW'(1));

    assert_hsat_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hs_fall && h_cnt == H_MAX) |=> h_cnt == H_MAX);

    assert_vstep_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_fall && !vs_fall && v_cnt != V_MAX) |=> v_cnt == $past(v_cnt) + VW'(1));

    assert_vclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vs_fall |=> (v_cnt == '0) && (field != $past(field)));

    assert_field_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_fall |=> $stable(field));

endmodule

// File: rtl/vrr_yuyv_pack.sv
// Four-byte packer for the Y,U,Y,V stream.
// Byte phase is taken from the horizontal count relative to the end of
// blanking, so every line restarts on a luma byte and a partial group is
// dropped. The first three bytes are held in lanes; the fourth completes the
// word, which is emitted when the line is active. Assumes the data byte is
// delayed to line up with the horizontal count.
module vrr_yuyv_pack
    import vrr_pkg::*;
#(
    parameter int HW     = 11,
    parameter int HBLANK = 276
) (
    input  logic          clk,
    input  logic          rst_n,
    input  vbyte_t        byte_d,
    input  logic [HW-1:0] h_cnt,
    input  logic          line_act,
    output pair_word_t    word,
    output logic          valid
);

    localparam logic [HW-1:0] HB_W  = HW'(HBLANK);
    localparam logic [HW-1:0] H_MAX = {HW{1'b1}};
    localparam int            HELD  = LANES - 1;

    logic          in_pic;
    logic [HW-1:0] offs;
    logic [1:0]    phase;
    vbyte_t        lane [HELD];

    // Byte phase within the current group.
    always_comb begin
        in_pic = (h_cnt >= HB_W) && (h_cnt != H_MAX);
        offs   = h_cnt - HB_W;
        phase  = offs[1:0];
    end

    generate
        for (genvar i = 0; i < HELD; i++) begin : g_lane
            vbyte_t q;
            // Capture the byte that belongs to lane i.
            always_ff @(posedge clk) begin
                if (!rst_n)                          q <= '0;
                else if (in_pic && phase == 2'(i))   q <= byte_d;
            end
            assign lane[i] = q;
        end
    endgenerate

    // Complete and emit the word on the last byte of a group.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word  <= '0;
            valid <= 1'b0;
        end else if (in_pic && phase == 2'(HELD) && line_act) begin
            word  <= '{y0: lane[0], cb: lane[1], y1: lane[2], cr: byte_d};
            valid <= 1'b1;
        end else begin
            valid <= 1'b0;
        end
    end

    assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |-> $stable(word));

    assert_strobe_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    assert_active_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(line_act));

    assert_after_blank_R7: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> $past(h_cnt) >= HB_W);

endmodule

// File: rtl/vid_raster_rx.sv
// Interlaced raster receiver top.
// Samples the decoder byte and syncs each pixel clock, derives raster
// position from sync falls, and packs Y,U,Y,V bytes into two-pixel words
// inside the active picture. The data byte passes through two registers so
// that it lines up with the horizontal count derived from the sync pipeline.
module vid_raster_rx #(
    parameter int LINE_CYCLES = 1716,
    parameter int FRAME_LINES = 525,
    parameter int HBLANK      = 276,
    parameter int VB_EVEN     = 20,
    parameter int VB_ODD      = 21,
    parameter int ACT_LINES   = 242
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [7:0]                     vd_data,
    input  logic                           hsync_n,
    input  logic                           vsync_n,
    output logic [31:0]                    pair_word,
    output logic                           pair_valid,
    output logic [$clog2(LINE_CYCLES)-1:0] h_pos,
    output logic [$clog2(FRAME_LINES)-1:0] line_pos,
    output logic                           field_odd
);
    import vrr_pkg::*;

    localparam int HW = $clog2(LINE_CYCLES);
    localparam int VW = $clog2(FRAME_LINES);

    vbyte_t     data_s1;
    vbyte_t     data_s2;
    logic [1:0] falls;
    logic       line_act;
    pair_word_t word;

    // Data byte delayed to match the sync sampling stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_s1 <= '0;
            data_s2 <= '0;
        end else begin
            data_s1 <= vd_data;
            data_s2 <= data_s1;
        end
    end

    vrr_sync_edge #(.N(2)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sync_n ({vsync_n, hsync_n}),
        .fall   (falls)
    );

    vrr_raster_count #(
        .HW        (HW),
        .VW        (VW),
        .VB_EVEN   (VB_EVEN),
        .VB_ODD    (VB_ODD),
        .ACT_LINES (ACT_LINES)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .hs_fall  (falls[0]),
        .vs_fall  (falls[1]),
        .h_cnt    (h_pos),
        .v_cnt    (line_pos),
        .field    (field_odd),
        .line_act (line_act)
    );

    vrr_yuyv_pack #(
        .HW     (HW),
        .HBLANK (HBLANK)
    ) u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .byte_d   (data_s2),
        .h_cnt    (h_pos),
        .line_act (line_act),
        .word     (word),
        .valid    (pair_valid)
    );

    assign pair_word = word;

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (!pair_valid && h_pos == '0 && line_pos == '0 && !field_odd));

endmodule

// File: tb/vid_raster_rx_test.sv
module vid_raster_rx_test;

    localparam int HB   = 20;
    localparam int VBE  = 3;
    localparam int VBO  = 4;
    localparam int ACT  = 5;
    localparam int HMAX = 2047;
    localparam int VMAX = 1023;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  din = '0;
    logic        hs_n = 1'b1;
    logic        vs_n = 1'b1;
    logic [31:0] pair_word;
    logic        pair_valid;
    logic [10:0] h_pos;
    logic [9:0]  line_pos;
    logic        field_odd;

    always #2 clk = ~clk;

    vid_raster_rx #(
        .HBLANK(HB), .VB_EVEN(VBE), .VB_ODD(VBO), .ACT_LINES(ACT)
    ) uut (
        .clk(clk), .rst_n(rst_n), .vd_data(din), .hsync_n(hs_n), .vsync_n(vs_n),
        .pair_word(pair_word), .pair_valid(pair_valid), .h_pos(h_pos),
        .line_pos(line_pos), .field_odd(field_odd)
    );

    int errors = 0;
    int checks = 0;
    bit done = 0;

    // Reference state after the most recent edge.
    int          mh = 0, mv = 0, mf = 0;
    bit          mvalid = 0;
    logic [31:0] mword = '0;
    bit          hq[$];
    bit          vq[$];
    logic [7:0]  dq[$];

    // Watch for the first word of a chosen line.
    bit          watch_first = 0;
    logic [7:0]  lb[0:4095];

    task automatic check(string req, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic model_edge(bit rst);
        bit hf, vf, inh, act;
        int lo;
        if (rst) begin
            mh = 0; mv = 0; mf = 0; mvalid = 0; mword = '0;
        end else begin
            hf  = (hq[$] == 0) && (hq[$-1] == 1);
            vf  = (vq[$] == 0) && (vq[$-1] == 1);
            lo  = mf ? VBO : VBE;
            act = (mv >= lo) && (mv < lo + ACT);
            inh = (mh >= HB) && (mh != HMAX);
            if (inh && ((mh - HB) % 4 == 3) && act) begin
                mvalid = 1;
                mword  = {dq[$-4], dq[$-3], dq[$-2], dq[$-1]};
            end else begin
                mvalid = 0;
            end
            mh = hf ? 0 : ((mh == HMAX) ? HMAX : mh + 1);
            if (vf) begin
                mv = 0;
                mf = 1 - mf;
            end else if (hf) begin
                mv = (mv == VMAX) ? VMAX : mv + 1;
            end
        end
    endtask

    // One clock: drive inputs, update model at the edge, compare after it.
    task automatic cycle(bit h, bit v, logic [7:0] d, bit rst);
        hs_n = h; vs_n = v; din = d; rst_n = !rst;
        @(posedge clk);
        model_edge(rst);
        hq.push_back(h); vq.push_back(v); dq.push_back(d);
        void'(hq.pop_front()); void'(vq.pop_front()); void'(dq.pop_front());
        @(negedge clk);
        if (rst) begin
            check("R1 h", h_pos, 0);
            check("R1 line", line_pos, 0);
            check("R1 field", field_odd, 0);
            check("R1 valid", pair_valid, 0);
            check("R1 word", pair_word, 0);
        end else begin
            check("R2 h_pos", h_pos, mh);
            check("R4 line_pos", line_pos, mv);
            check("R5 field", field_odd, mf);
            check("R6 valid", pair_valid, mvalid);
            check(mvalid ? "R7 word" : "R8 word hold", pair_word, mword);
            if (watch_first && pair_valid) begin
                watch_first = 0;
                check("R9 first word", pair_word, {lb[HB], lb[HB+1], lb[HB+2], lb[HB+3]});
            end
        end
    endtask

    task automatic gen_line(int len, int hs_low, bit vs_low);
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            b = 8'($urandom);
            if (i < 4096) lb[i] = b;
            cycle(i >= hs_low, !vs_low, b, 0);
        end
    endtask

    initial begin
        for (int i = 0; i < 8; i++) begin
            hq.push_back(1); vq.push_back(1); dq.push_back(8'h00);
        end
        for (int i = 0; i < 4; i++) cycle(1, 1, 8'h00, 1);

        gen_line(40, 2, 0);
        gen_line(40, 2, 0);

        // Two fields; the vertical sync falls together with a horizontal fall.
        for (int f = 0; f < 2; f++) begin
            int fb;
            fb = (f == 0) ? VBO : VBE;
            for (int k = 0; k < fb + ACT + 2; k++) begin
                int len, hl;
                len = (k == fb + 1) ? 58 : 60;
                hl  = (k == fb + 2) ? 3 : 2;
                if (k == fb + 2) watch_first = 1;
                gen_line(len, hl, k < 3);
                if (k == 0) begin
                    check("R5 field after vertical fall", field_odd, (f == 0) ? 1 : 0);
                end
            end
        end

        // Long line inside the active window: horizontal counter must stop.
        for (int k = 0; k < 3; k++) gen_line(30, 2, k == 0);
        gen_line(30, 2, 0);
        gen_line(30, 2, 0);
        gen_line(2100, 2, 0);
        check("R3 h saturated", h_pos, HMAX);
        gen_line(60, 2, 0);

        // Many short lines: line counter must stop at all-ones.
        for (int k = 0; k < 1030; k++) gen_line(8, 2, 0);
        check("R4 line saturated", line_pos, VMAX);

        // Reset in the middle of a stream.
        gen_line(30, 2, 0);
        for (int i = 0; i < 3; i++) cycle(1, 1, 8'h00, 1);
        check("R1 h after reset", h_pos, 0);
        check("R1 field after reset", field_odd, 0);
        gen_line(40, 2, 0);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1;
            errors++;
            checks++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule